// File: doc/BRIEF.md
# Serial PHY Management Master with Link Polling

This block is the management side of an Ethernet port. It drives the management clock and a bidirectional management data line. Over that one shared two-wire bus it reads and writes the 16-bit registers of up to two PHYs using the clause-22 frame. Software works through a small register port. It writes a command word into one of two user channels. It watches the start bit fall, or waits for the completion interrupt. It then reads back the returned data and the acknowledge flag.

Each channel also has a PHY select word. When polling is switched on there, the master reads register 1 of the selected PHY whenever no user command is waiting. It records bit 2 of that register as the PHY's link state. If the link state changes and the channel's interrupt enable is set, a link-change interrupt is raised. The management clock is the peripheral clock divided down by a programmable factor, and the 32-bit preamble can be suppressed.

Top module: `mdio_master`

Register map (3-bit word address):
- 0: control. Bit 31 is the idle flag (read only), bit 30 enables the bus, bit 20 suppresses the preamble, and bits 7:0 hold the divider.
- 1: acknowledge record. One bit per PHY address, cleared by writing 1.
- 2: link state. One bit per PHY address.
- 3: event status. Bits 1:0 are command done for channels 0 and 1, bits 3:2 are link change for channels 0 and 1. Written 1 clears a bit.
- 4 and 5: command words for channels 0 and 1.
- 6 and 7: select words for channels 0 and 1.

## Requirements
- R1: The management clock toggles every (DIV+1) peripheral clocks, so its period is (DIV+1)×2 clocks, where DIV is control bits 7:0 (reset value 1). While control bit 30 is 0 the clock is held low, and the bus enable resets to 0.
- R2: A frame sends 32 ones of preamble, then start bits 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address, then the 5-bit register address. A write continues with turnaround 10 and the 16 data bits. All fields go out most significant bit first.
- R3: With control bit 20 set, the 32 preamble ones are left out and the frame begins at its start bits.
- R4: On a read, the master stops driving the line from the first turnaround bit to the end of the frame. It captures the 16 data bits into command-word bits 15:0. It sets command-word bit 29 to 1 only if the PHY held the line at 0 in the second turnaround bit; otherwise bit 29 is 0.
- R5: In a command word, bit 31 starts the command and bit 30 selects a write. Bits 25:21 hold the register address and bits 20:16 the PHY address. When the frame completes, the hardware clears bit 31 and sets the channel's done bit in the status word. The user interrupt output stays high while any done bit is set. The idle flag is 1 only when no frame runs and no start bit is set.
- R6: A write to a command word whose start bit is still set is ignored.
- R7: When both channels have their start bits set, channel 0's frame goes out first.
- R8: A read that is acknowledged sets the record bit for its PHY address. Writing 1 to a record bit clears it.
- R9: When select bit 7 is set, the master polls register 1 of the PHY named by select bits 4:0, but only while no start bit is pending. It stores bit 2 of the answer (0 if unacknowledged) as that PHY's link bit. A change of link state sets the channel's link-change bit only if select bit 6 is set, and the link interrupt output stays high while any link-change bit is set.
- R10: The data line changes only in the clock in which the management clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Master drives the data line when 1 |
| mdio_in | input | 1 | Data line value as seen on the bus |
| irq_user | output | 1 | Command completion interrupt |
| irq_link | output | 1 | Link change interrupt |

## Verification
The hardest case to reach from the ports is two user commands colliding. Once polling runs, the bus is nearly always busy, so two start bits rarely rise before an arbitration point. The stimulus therefore parks the bus by clearing the enable, loads channel 1 and then channel 0, and enables again, so both requests meet at the same decision. Link-change events need a PHY whose status register changes between polls. The modelled PHY's register 1 is rewritten while polling runs, both with the interrupt enable set and with it clear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int NCH        = 2;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int FIRST_RX   = 17;  // first bit position the PHY may own
  localparam int ACK_POS    = 16;  // second turnaround bit
  localparam logic [4:0] LINK_REG = 5'd1;
  localparam int LINK_BIT   = 2;

  typedef struct packed {
    logic        wr;
    logic [4:0]  regad;
    logic [4:0]  phy;
    logic [15:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick = en && (cnt_q == div);
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise,
  input  logic        fall,
  input  logic        start,
  input  logic        pre_en,
  input  mdio_cmd_t   cmd,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic        ack,
  output logic [15:0] rdata
);
  localparam int CW = $clog2(PRE_BITS + 1);

  logic [FRAME_BITS-1:0] word_q;
  logic [CW-1:0]         pre_left, bits_left;
  logic                  wr_q, on_frame, busy_q, out_q, oe_q, done_q, ack_q;
  logic [15:0]           rd_q;
  logic [4:0]            nxt;

  assign nxt = bits_left[4:0] - 5'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; out_q <= 1'b1; oe_q <= 1'b0; done_q <= 1'b0;
      ack_q <= 1'b0; rd_q <= '0; on_frame <= 1'b0; wr_q <= 1'b0;
      pre_left <= '0; bits_left <= '0; word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q    <= 1'b1;
        wr_q      <= cmd.wr;
        word_q    <= {2'b01, cmd.wr ? 2'b01 : 2'b10, cmd.phy, cmd.regad,
                      cmd.wr ? 2'b10 : 2'b11, cmd.wr ? cmd.data : 16'hFFFF};
        pre_left  <= pre_en ? CW'(PRE_BITS) : '0;
        bits_left <= CW'(FRAME_BITS);
        on_frame  <= 1'b0;
        ack_q     <= 1'b0;
        rd_q      <= '0;
      end else if (busy_q && fall) begin
        if (pre_left != '0) begin
          out_q    <= 1'b1;
          oe_q     <= 1'b1;
          pre_left <= pre_left - 1'b1;
        end else if (bits_left != '0) begin
          out_q     <= word_q[nxt];
          oe_q      <= wr_q || (bits_left > CW'(FIRST_RX + 1));
          bits_left <= bits_left - 1'b1;
          on_frame  <= 1'b1;
        end else begin
          busy_q   <= 1'b0;
          oe_q     <= 1'b0;
          out_q    <= 1'b1;
          on_frame <= 1'b0;
          done_q   <= 1'b1;
        end
      end else if (busy_q && rise && on_frame && !wr_q) begin
        if (bits_left == CW'(ACK_POS))     ack_q <= !mdio_in;
        else if (bits_left < CW'(ACK_POS)) rd_q  <= {rd_q[14:0], mdio_in};
      end
    end
  end

  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign ack      = ack_q;
  assign rdata    = rd_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         DIV_W      = 8,
  parameter logic [7:0] CLKDIV_RST = 8'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in,
  output logic        irq_user,
  output logic        irq_link
);
  localparam int DIV_PAD = 20 - DIV_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_ALIVE = 3'd1, A_LINK = 3'd2,
                         A_STAT = 3'd3, A_ACC = 3'd4, A_SEL = 3'd6;

  logic             en_q, presup_q;
  logic [DIV_W-1:0] div_q;
  logic [NCH-1:0]   go_q, ackb_q, ustat_q, lstat_q, poll_q, ien_q;
  mdio_cmd_t        acc_q [NCH];
  logic [4:0]       selphy_q [NCH];
  logic [31:0]      alive_q, link_q;
  logic             poll_ptr, own_user, own_ch;
  logic [4:0]       own_phy;

  logic rise, fall, eng_busy, eng_done, eng_ack, start;
  logic [15:0] eng_rdata;
  logic any_go, any_poll, user_ch, poll_ch, link_new;
  mdio_cmd_t cmd;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .div(div_q),
    .mdc(mdc), .rise(rise), .fall(fall));

  assign any_go   = |go_q;
  assign user_ch  = !go_q[0];
  assign any_poll = |poll_q;
  assign poll_ch  = poll_q[poll_ptr] ? poll_ptr : !poll_ptr;
  assign start    = en_q && !eng_busy && !eng_done && (any_go || any_poll);
  assign link_new = eng_ack && eng_rdata[LINK_BIT];

  always_comb begin
    if (any_go) cmd = acc_q[user_ch];
    else        cmd = '{wr: 1'b0, regad: LINK_REG, phy: selphy_q[poll_ch], data: 16'h0};
  end

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .start(start),
    .pre_en(!presup_q), .cmd(cmd), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .busy(eng_busy),
    .done(eng_done), .ack(eng_ack), .rdata(eng_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; presup_q <= 1'b0; div_q <= DIV_W'(CLKDIV_RST);
      go_q <= '0; ackb_q <= '0; ustat_q <= '0; lstat_q <= '0;
      poll_q <= '0; ien_q <= '0; alive_q <= '0; link_q <= '0;
      poll_ptr <= 1'b0; own_user <= 1'b0; own_ch <= 1'b0; own_phy <= '0;
      for (int c = 0; c < NCH; c++) begin
        acc_q[c]    <= '0;
        selphy_q[c] <= '0;
      end
    end else begin
      if (reg_wr) begin
        if (reg_addr == A_CTRL) begin
          en_q     <= reg_wdata[30];
          presup_q <= reg_wdata[20];
          div_q    <= reg_wdata[DIV_W-1:0];
        end
        if (reg_addr == A_ALIVE) alive_q <= alive_q & ~reg_wdata;
        if (reg_addr == A_STAT) begin
          ustat_q <= ustat_q & ~reg_wdata[NCH-1:0];
          lstat_q <= lstat_q & ~reg_wdata[2*NCH-1:NCH];
        end
        for (int c = 0; c < NCH; c++) begin
          if (reg_addr == 3'(A_ACC + c) && !go_q[c]) begin
            acc_q[c] <= '{wr: reg_wdata[30], regad: reg_wdata[25:21],
                          phy: reg_wdata[20:16], data: reg_wdata[15:0]};
            go_q[c]   <= reg_wdata[31];
            ackb_q[c] <= 1'b0;
          end
          if (reg_addr == 3'(A_SEL + c)) begin
            poll_q[c]   <= reg_wdata[7];
            ien_q[c]    <= reg_wdata[6];
            selphy_q[c] <= reg_wdata[4:0];
          end
        end
      end
      if (start) begin
        own_user <= any_go;
        own_ch   <= any_go ? user_ch : poll_ch;
        own_phy  <= cmd.phy;
        if (!any_go) poll_ptr <= !poll_ch;
      end
      if (eng_done) begin
        if (eng_ack) alive_q[own_phy] <= 1'b1;
        if (own_user) begin
          go_q[own_ch]    <= 1'b0;
          ustat_q[own_ch] <= 1'b1;
          if (!acc_q[own_ch].wr) begin
            acc_q[own_ch].data <= eng_rdata;
            ackb_q[own_ch]     <= eng_ack;
          end
        end else if (link_q[own_phy] != link_new) begin
          link_q[own_phy] <= link_new;
          if (ien_q[own_ch]) lstat_q[own_ch] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {!eng_busy && !any_go, en_q, 9'b0, presup_q,
                            {DIV_PAD{1'b0}}, div_q};
      A_ALIVE: reg_rdata = alive_q;
      A_LINK:  reg_rdata = link_q;
      A_STAT:  reg_rdata = {{(32-2*NCH){1'b0}}, lstat_q, ustat_q};
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (reg_addr == 3'(A_ACC + c))
            reg_rdata = {go_q[c], acc_q[c].wr, ackb_q[c], 3'b0, acc_q[c].regad,
                         acc_q[c].phy, acc_q[c].data};
          if (reg_addr == 3'(A_SEL + c))
            reg_rdata = {24'b0, poll_q[c], ien_q[c], 1'b0, selphy_q[c]};
        end
      end
    endcase
  end

  assign irq_user = |ustat_q;
  assign irq_link = |lstat_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        en,
  input logic        busy,
  input logic        done,
  input logic [1:0]  go,
  input logic [31:0] alive,
  input logic        reg_wr
);
  // R10
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_out) |-> $fell(mdc));

  // R1
  mdc_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

  // R5
  go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(go) & ~go)) |-> $past(done));

  // R8
  alive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alive) |-> ($past(reg_wr) || $past(done)));

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out),
  .mdio_oe(mdio_oe), .en(en_q), .busy(eng_busy), .done(eng_done),
  .go(go_q), .alive(alive_q), .reg_wr(reg_wr));

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in, irq_user, irq_link;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = !clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
    .irq_user(irq_user), .irq_link(irq_link));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // clock reference model (R1)
  logic       m_en = 1'b0, m_mdc = 1'b0;
  logic [7:0] m_div = 8'd1, m_cnt = 8'd0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 1'b0; m_div <= 8'd1; m_cnt <= 8'd0; m_mdc <= 1'b0;
    end else begin
      if (!m_en) begin
        m_cnt <= 8'd0; m_mdc <= 1'b0;
      end else if (m_cnt == m_div) begin
        m_cnt <= 8'd0; m_mdc <= !m_mdc;
      end else m_cnt <= m_cnt + 8'd1;
      if (reg_wr && reg_addr == 3'd0) begin
        m_en <= reg_wdata[30]; m_div <= reg_wdata[7:0];
      end
    end
  end

  // PHY model and frame decoder
  logic [15:0] mem [0:31][0:31];
  logic drv_en = 1'b0, drv = 1'b1, prev_mdc = 1'b0, prev_out = 1'b1;
  assign mdio_in = drv_en ? drv : 1'b1;
  int st = 0, cnt = 0, ones = 0, f_pre = 0;
  logic [11:0] hdr;
  logic [17:0] dat;
  logic [15:0] rword;
  int q_op[$], q_phy[$], q_reg[$], q_dat[$], q_pre[$];

  function automatic bit present(int p);
    return p == 3 || p == 9;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      // R1 clock compare every cycle
      check("R1 mdc", {31'b0, mdc}, {31'b0, m_mdc});
      // R10 line only changes with a falling clock
      if (mdio_out !== prev_out)
        check("R10 launch edge", {31'b0, prev_mdc && !mdc}, 32'd1);
      if (mdc && !prev_mdc) begin
        logic line;
        line = mdio_oe ? mdio_out : mdio_in;
        case (st)
          0: if (mdio_oe) begin
               if (line) ones++;
               else begin f_pre = ones; ones = 0; st = 1; end
             end
          1: begin check("R2 start bit", {31'b0, line}, 32'd1); st = 2; cnt = 0; end
          2: begin
               hdr = {hdr[10:0], line}; cnt++;
               if (cnt == 12) begin
                 if (hdr[11:10] == 2'b10) begin
                   rword = mem[hdr[9:5]][hdr[4:0]];
                   drv_en = 1'b0; st = 3;
                 end else begin st = 5; cnt = 0; end
               end
             end
          3: begin
               check("R4 release ta1", {31'b0, mdio_oe}, 32'd0);
               if (present(int'(hdr[9:5]))) begin drv_en = 1'b1; drv = 1'b0; end
               st = 4;
             end
          4: begin
               check("R4 release ta2", {31'b0, mdio_oe}, 32'd0);
               cnt = 15; drv = rword[15]; st = 6;
             end
          6: begin
               check("R4 release data", {31'b0, mdio_oe}, 32'd0);
               if (cnt == 0) begin
                 drv_en = 1'b0; drv = 1'b1;
                 q_op.push_back(int'(hdr[11:10])); q_phy.push_back(int'(hdr[9:5]));
                 q_reg.push_back(int'(hdr[4:0]));
                 q_dat.push_back(present(int'(hdr[9:5])) ? int'(rword) : 32'hFFFF);
                 q_pre.push_back(f_pre); st = 0;
               end else begin cnt--; drv = rword[cnt]; end
             end
          5: begin
               dat = {dat[16:0], line}; cnt++;
               if (cnt == 18) begin
                 check("R2 write turnaround", {30'b0, dat[17:16]}, 32'd2);
                 if (present(int'(hdr[9:5]))) mem[hdr[9:5]][hdr[4:0]] = dat[15:0];
                 q_op.push_back(int'(hdr[11:10])); q_phy.push_back(int'(hdr[9:5]));
                 q_reg.push_back(int'(hdr[4:0])); q_dat.push_back(int'(dat[15:0]));
                 q_pre.push_back(f_pre); st = 0;
               end
             end
          default: st = 0;
        endcase
      end
    end
    prev_mdc = mdc;
    prev_out = mdio_out;
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic flush();
    q_op.delete(); q_phy.delete(); q_reg.delete(); q_dat.delete(); q_pre.delete();
  endtask

  task automatic wait_go(logic [2:0] a, string tag);
    logic [31:0] v;
    for (int i = 0; i < 6000; i++) begin
      rd(a, v);
      if (!v[31]) break;
    end
    check(tag, {31'b0, v[31]}, 32'd0);
  endtask

  task automatic wait_frames(int n);
    for (int i = 0; i < 6000 && q_op.size() < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq_link(string tag);
    for (int i = 0; i < 6000 && !irq_link; i++) @(negedge clk);
    check(tag, {31'b0, irq_link}, 32'd1);
  endtask

  function automatic logic [31:0] cmdw(bit go, bit w, int r, int p, int d);
    return {go, w, 1'b0, 3'b0, 5'(r), 5'(p), 16'(d)};
  endfunction

  initial begin
    logic [31:0] v;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) mem[p][r] = 16'h0;
    mem[9][2] = 16'h5A0F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, v); check("R5 reset control/idle", v, 32'h8000_0001);
    check("R5 reset irq_user", {31'b0, irq_user}, 32'd0);
    check("R9 reset irq_link", {31'b0, irq_link}, 32'd0);
    rd(3'd2, v); check("R9 reset link", v, 32'h0);
    check("R1 reset mdc", {31'b0, mdc}, 32'd0);

    wr(3'd0, 32'h4000_0001);
    // R2 write frame on channel 0
    flush();
    wr(3'd4, cmdw(1, 1, 4, 3, 16'hA5C3));
    wait_go(3'd4, "R5 go clears ch0");
    wait_frames(1);
    check("R2 frame count", q_op.size(), 32'd1);
    if (q_op.size() > 0) begin
      check("R2 preamble", q_pre[0], 32'd32);
      check("R2 write opcode", q_op[0], 32'd1);
      check("R2 phy field", q_phy[0], 32'd3);
      check("R2 reg field", q_reg[0], 32'd4);
      check("R2 write data", q_dat[0], 32'hA5C3);
    end
    rd(3'd4, v); check("R5 ch0 word after", v, cmdw(0, 1, 4, 3, 16'hA5C3));
    rd(3'd3, v); check("R5 done bit ch0", v, 32'd1);
    check("R5 irq_user set", {31'b0, irq_user}, 32'd1);
    wr(3'd3, 32'd1);
    check("R5 irq_user cleared", {31'b0, irq_user}, 32'd0);

    // R4 read back on channel 1
    flush();
    wr(3'd5, cmdw(1, 0, 4, 3, 0));
    wait_go(3'd5, "R5 go clears ch1");
    rd(3'd5, v); check("R4 read data and ack", v, 32'h2083_A5C3);
    if (q_op.size() > 0) check("R2 read opcode", q_op[0], 32'd2);
    rd(3'd3, v); check("R5 done bit ch1", v, 32'd2);
    wr(3'd3, 32'd2);
    rd(3'd1, v); check("R8 alive set", v, 32'h0000_0008);

    // R4 absent PHY: no acknowledge
    wr(3'd4, cmdw(1, 0, 1, 7, 0));
    wait_go(3'd4, "R5 go clears absent");
    rd(3'd4, v); check("R4 no ack", v, {3'b000, 3'b0, 5'd1, 5'd7, 16'hFFFF});
    rd(3'd1, v); check("R8 alive untouched by nak", v, 32'h0000_0008);
    wr(3'd1, 32'h0000_0008);
    rd(3'd1, v); check("R8 alive w1c", v, 32'h0);
    wr(3'd3, 32'hF);

    // R3 preamble suppressed
    flush();
    wr(3'd0, 32'h4010_0001);
    wr(3'd4, cmdw(1, 0, 4, 3, 0));
    wait_go(3'd4, "R5 go clears nopre");
    wait_frames(1);
    if (q_pre.size() > 0) check("R3 no preamble", q_pre[0], 32'd0);
    rd(3'd4, v); check("R3 data still read", v[15:0], 32'hA5C3);

    // R1 slower divider with a write frame
    flush();
    wr(3'd0, 32'h4000_0003);
    wr(3'd4, cmdw(1, 1, 6, 9, 16'h1357));
    wait_go(3'd4, "R5 go clears div3");
    wait_frames(1);
    if (q_dat.size() > 0) check("R1 frame at div3", q_dat[0], 32'h1357);
    wr(3'd0, 32'h4000_0001);

    // R6 rewrite while busy is ignored
    flush();
    wr(3'd4, cmdw(1, 0, 5, 3, 0));
    wr(3'd4, cmdw(1, 1, 6, 9, 16'hBEEF));
    wait_go(3'd4, "R5 go clears R6");
    wait_frames(1);
    if (q_reg.size() > 0) check("R6 original reg kept", q_reg[0], 32'd5);
    rd(3'd4, v); check("R6 word fields kept", v[29:16], {1'b1, 3'b0, 5'd5, 5'd3});
    check("R6 mem untouched", {16'h0, mem[9][6]}, 32'h1357);

    // R7 priority: park the bus, queue both, release
    flush();
    wr(3'd0, 32'h0000_0001);
    check("R1 parked mdc", {31'b0, mdc}, 32'd0);
    wr(3'd5, cmdw(1, 0, 2, 9, 0));
    wr(3'd4, cmdw(1, 1, 7, 3, 16'h1234));
    rd(3'd0, v); check("R5 idle low with go pending", {31'b0, v[31]}, 32'd0);
    wr(3'd0, 32'h4000_0001);
    wait_go(3'd5, "R5 go clears prio");
    wait_frames(2);
    if (q_op.size() > 1) begin
      check("R7 ch0 first", q_phy[0], 32'd3);
      check("R7 ch0 first op", q_op[0], 32'd1);
      check("R7 ch1 second", q_phy[1], 32'd9);
    end
    rd(3'd5, v); check("R7 ch1 read data", v[15:0], 32'h5A0F);
    wr(3'd3, 32'hF);

    // R9 polling with link interrupt enabled
    mem[9][1] = 16'h0004;
    flush();
    wr(3'd6, 32'h0000_00C9);
    wait_irq_link("R9 link up irq");
    rd(3'd3, v); check("R9 status link ch0", v, 32'd4);
    rd(3'd2, v); check("R9 link bit up", v, 32'h0000_0200);
    if (q_reg.size() > 0) check("R9 polls reg 1", q_reg[0], 32'd1);
    wr(3'd3, 32'd4);
    check("R9 irq_link cleared", {31'b0, irq_link}, 32'd0);
    // user command takes the bus while polling
    wr(3'd5, cmdw(1, 1, 8, 3, 16'h0F0F));
    wait_go(3'd5, "R9 user wins over poll");
    check("R9 user write landed", {16'h0, mem[3][8]}, 32'h0F0F);
    wr(3'd3, 32'hF);
    mem[9][1] = 16'h0000;
    wait_irq_link("R9 link down irq");
    rd(3'd2, v); check("R9 link bit down", v, 32'h0);
    wr(3'd3, 32'hF);
    // interrupt enable cleared: link tracks, no interrupt
    wr(3'd6, 32'h0000_0089);
    mem[9][1] = 16'h0004;
    for (int i = 0; i < 6000; i++) begin
      rd(3'd2, v);
      if (v[9]) break;
    end
    check("R9 link tracked without ien", v, 32'h0000_0200);
    check("R9 no irq without ien", {31'b0, irq_link}, 32'd0);
    rd(3'd3, v); check("R9 status clear without ien", v, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule